// File: doc/BRIEF.md
# Eighteen-bit three-wire tuning word receiver

This block receives tuning words for a frequency synthesizer over a slow three-wire serial link (serial clock, serial data, enable). A fast system clock oversamples all three wires through synchronizers. While enable is high, every falling edge of the serial clock shifts in one data bit. When enable falls, the block looks at how many serial-clock falls it counted. If the count is exactly eighteen, the captured word is committed to the output latches. Any other count discards the word.

A word carries four band-select bits first, in the order B1, B2, B3, B4. They are followed by a 14-bit divider scaling factor, sent least-significant bit first. The band bits are decoded into band-enable outputs and a trap-filter enable. A zero scaling factor switches the whole loop off. On this link the reference divider ratio is fixed at 512 and the charge pump always uses its high current. A lock indicator mirrors the loop's lock-detect input, delayed by one register stage, but only while the loop is enabled.

Top module: `tw_frame_rx`

## Requirements
- R1: After reset, scaleFactor is 0, all band outputs and fmTrapOn are 0, pumpEnable and driveEnable are 0, and lockInd is 0.
- R2: A data bit is captured on each falling edge of busClk while busEn is high. The first four bits are B1..B4, which become code bits 3..0. The next fourteen bits are scaleFactor bits 0..13, in that order. The word is committed when busEn falls after exactly 18 clock falls.
- R3: If busEn falls after any count of clock falls other than 18 (for example 0, 17 or 19), every output latch keeps its previous value.
- R4: Falling edges of busClk while busEn is low shift nothing and add nothing to the count. A following correct frame still commits exactly its own bits.
- R5: The fall counter saturates at 31, so a burst of 50 falls never commits.
- R6: The band code B1..B4 decodes as follows: 1000 sets uhfOn; 0100 sets vhfHighOn; 0010 sets vhfLowOn; 0011 sets vhfLowOn and fmTrapOn.
- R7: Every other band code drives uhfOn, vhfHighOn, vhfLowOn and fmTrapOn all to 0.
- R8: pumpEnable and driveEnable are 1 exactly when the committed scaleFactor is nonzero.
- R9: refDivRatio is always 512 and pumpHighCurrent is always 1.
- R10: lockInd equals loopLocked from one clock earlier while the committed scaleFactor is nonzero. lockInd is 0 while scaleFactor is 0.
- R11: A busClk fall sampled in the same system-clock cycle as the busEn fall counts as a frame bit. It is included both in the count and in the committed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the link |
| rstN | input | 1 | Active-low synchronous reset |
| busClk | input | 1 | Serial clock; bits are taken on its falling edge |
| busData | input | 1 | Serial data |
| busEn | input | 1 | Frame enable; its falling edge requests a commit |
| loopLocked | input | 1 | Lock-detect status from the loop |
| scaleFactor | output | 14 | Committed divider scaling factor |
| uhfOn | output | 1 | Upper band enable |
| vhfHighOn | output | 1 | Lower band, high segment enable |
| vhfLowOn | output | 1 | Lower band, low segment enable |
| fmTrapOn | output | 1 | Trap filter enable |
| pumpEnable | output | 1 | Charge pump enable |
| driveEnable | output | 1 | Tuning drive enable |
| pumpHighCurrent | output | 1 | Charge pump current select, always high |
| refDivRatio | output | 10 | Reference divider ratio, fixed |
| lockInd | output | 1 | Lock indicator |

## Verification
The 18th serial-clock fall and the enable fall can land in the same system-clock cycle. In that cycle the block must shift the bit, bump the count and judge the commit all at once. The bench provokes this by switching busClk low and busEn low in the same drive step, so both pass through identical synchronizers. It then expects a commit carrying the final bit as the scaleFactor MSB. The same collision is also driven with 17 and 19 falls, where both must leave the latches unchanged.

// File: rtl/tw_rx_pkg.sv
package tw_rx_pkg;
  parameter int FRAME_BITS = 18;
  parameter int SW_BITS    = 4;
  parameter int SF_BITS    = FRAME_BITS - SW_BITS;
  parameter int CNT_SAT    = 31;
  parameter int CNT_W      = $clog2(CNT_SAT + 1);
  parameter int REF_DIV    = 512;
  parameter int REF_W      = $clog2(REF_DIV) + 1;
  parameter int SYNC_STAGES = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;
    logic commit;
    logic dataBit;
  } rxStrobe_t;

  typedef enum logic [SW_BITS-1:0] {
    CODE_UHF   = 4'b1000,
    CODE_VHFHI = 4'b0100,
    CODE_VHFLO = 4'b0010,
    CODE_CH6   = 4'b0011
  } bandCode_e;
endpackage

// File: rtl/tw_rx_ctrl.sv
module tw_rx_ctrl
  import tw_rx_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      busClk,
  input  logic      busData,
  input  logic      busEn,
  output rxStrobe_t strb
);
  localparam int NW = 3;

  logic [NW-1:0] syncReg [STAGES];
  logic [NW-1:0] rawIn;
  logic [NW-1:0] synced;
  logic          prevClk;
  logic          prevEn;
  logic          clkFall;
  logic          enFall;

  assign rawIn = {busEn, busData, busClk};

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) begin
          syncReg[s] <= '0;
        end else if (s == 0) begin
          syncReg[s] <= rawIn;
        end else begin
          syncReg[s] <= syncReg[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign synced = syncReg[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevEn  <= 1'b0;
    end else begin
      prevClk <= synced[0];
      prevEn  <= synced[2];
    end
  end

  assign clkFall = prevClk & ~synced[0];
  assign enFall  = prevEn & ~synced[2];

  // a clock fall counts if enable was high in the sample before it,
  // so a fall coinciding with the enable fall still belongs to the frame
  always_comb begin
    strb.shift   = clkFall & prevEn;
    strb.commit  = enFall;
    strb.dataBit = synced[1];
  end
endmodule

// File: rtl/tw_rx_dp.sv
module tw_rx_dp
  import tw_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strb,
  input  logic              loopLocked,
  output logic [SF_BITS-1:0] scaleFactor,
  output logic              uhfOn,
  output logic              vhfHighOn,
  output logic              vhfLowOn,
  output logic              fmTrapOn,
  output logic              pllOn,
  output logic              lockInd,
  output logic              frameTaken
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(CNT_SAT);

  logic [FRAME_BITS-1:0] shReg, nextSh;
  logic [CNT_W-1:0]      cnt, nextCnt;
  logic [SW_BITS-1:0]    codeQ;
  logic [SF_BITS-1:0]    sfQ, sfIn;

  always_comb begin
    nextSh  = shReg;
    nextCnt = cnt;
    if (strb.shift) begin
      nextSh  = {shReg[FRAME_BITS-2:0], strb.dataBit};
      nextCnt = (cnt == SAT_CNT) ? cnt : cnt + 1'b1;
    end
  end

  assign frameTaken = strb.commit && (nextCnt == FULL_CNT);

  // scaling factor arrives LSB first, so it sits reversed in the shifter
  genvar k;
  generate
    for (k = 0; k < SF_BITS; k++) begin : g_rev
      assign sfIn[k] = nextSh[SF_BITS-1-k];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      cnt   <= '0;
      codeQ <= '0;
      sfQ   <= '0;
    end else begin
      shReg <= nextSh;
      cnt   <= strb.commit ? '0 : nextCnt;
      if (frameTaken) begin
        codeQ <= nextSh[FRAME_BITS-1:SF_BITS];
        sfQ   <= sfIn;
      end
    end
  end

  always_comb begin
    uhfOn     = 1'b0;
    vhfHighOn = 1'b0;
    vhfLowOn  = 1'b0;
    fmTrapOn  = 1'b0;
    case (codeQ)
      CODE_UHF:   uhfOn = 1'b1;
      CODE_VHFHI: vhfHighOn = 1'b1;
      CODE_VHFLO: vhfLowOn = 1'b1;
      CODE_CH6: begin
        vhfLowOn = 1'b1;
        fmTrapOn = 1'b1;
      end
      default: ;
    endcase
  end

  assign scaleFactor = sfQ;
  assign pllOn       = |sfQ;

  always_ff @(posedge clk) begin
    if (!rstN) lockInd <= 1'b0;
    else       lockInd <= loopLocked & pllOn;
  end
endmodule

// File: rtl/tw_frame_rx.sv
module tw_frame_rx
  import tw_rx_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busClk,
  input  logic               busData,
  input  logic               busEn,
  input  logic               loopLocked,
  output logic [SF_BITS-1:0] scaleFactor,
  output logic               uhfOn,
  output logic               vhfHighOn,
  output logic               vhfLowOn,
  output logic               fmTrapOn,
  output logic               pumpEnable,
  output logic               driveEnable,
  output logic               pumpHighCurrent,
  output logic [REF_W-1:0]   refDivRatio,
  output logic               lockInd
);
  rxStrobe_t strb;
  logic      pllOn;
  logic      frameTaken;

  tw_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busData(busData),
    .busEn(busEn), .strb(strb)
  );

  tw_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loopLocked(loopLocked),
    .scaleFactor(scaleFactor), .uhfOn(uhfOn), .vhfHighOn(vhfHighOn),
    .vhfLowOn(vhfLowOn), .fmTrapOn(fmTrapOn), .pllOn(pllOn),
    .lockInd(lockInd), .frameTaken(frameTaken)
  );

  assign pumpEnable      = pllOn;
  assign driveEnable     = pllOn;
  assign pumpHighCurrent = 1'b1;
  assign refDivRatio     = REF_W'(REF_DIV);
endmodule

// File: rtl/tw_frame_rx_chk.sv
module tw_frame_rx_chk
  import tw_rx_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               frameTaken,
  input logic               loopLocked,
  input logic [SF_BITS-1:0] scaleFactor,
  input logic               uhfOn,
  input logic               vhfHighOn,
  input logic               vhfLowOn,
  input logic               fmTrapOn,
  input logic               pumpEnable,
  input logic               driveEnable,
  input logic               lockInd
);
  // latches move only on an accepted frame
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(frameTaken) |-> ($stable(scaleFactor) && $stable({uhfOn, vhfHighOn, vhfLowOn, fmTrapOn})));

  assert_band_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({uhfOn, vhfHighOn, vhfLowOn}));

  assert_trap_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    fmTrapOn |-> vhfLowOn);

  assert_zero_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (scaleFactor == '0) |-> (!pumpEnable && !driveEnable));

  assert_lock_src_R10: assert property (@(posedge clk) disable iff (!rstN)
    lockInd |-> $past(loopLocked));
endmodule

bind tw_frame_rx tw_frame_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .frameTaken(frameTaken), .loopLocked(loopLocked),
  .scaleFactor(scaleFactor), .uhfOn(uhfOn), .vhfHighOn(vhfHighOn),
  .vhfLowOn(vhfLowOn), .fmTrapOn(fmTrapOn), .pumpEnable(pumpEnable),
  .driveEnable(driveEnable), .lockInd(lockInd)
);

// File: tb/tw_frame_rx_tb_top.sv
module tw_frame_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0, busData = 1'b0, busEn = 1'b0, loopLocked = 1'b0;
  logic [13:0] scaleFactor;
  logic uhfOn, vhfHighOn, vhfLowOn, fmTrapOn, pumpEnable, driveEnable;
  logic pumpHighCurrent, lockInd;
  logic [9:0] refDivRatio;

  int nChecks = 0, nFails = 0;
  logic [3:0]  expCode = '0;
  logic [13:0] expSf = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  tw_frame_rx dut_i (.*);

  function automatic logic [17:0] mkWord(input logic [3:0] code, input logic [13:0] sf);
    logic [17:0] w;
    w[17:14] = code;
    for (int k = 0; k < 14; k++) w[13-k] = sf[k];
    return w;
  endfunction

  function automatic logic [3:0] expBands(input logic [3:0] code);
    case (code) // {uhf, vhfHigh, vhfLow, fmTrap}
      4'b1000: return 4'b1000;
      4'b0100: return 4'b0100;
      4'b0010: return 4'b0010;
      4'b0011: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // nFalls clock falls while enable high; coincide puts the last fall with enable fall
  task automatic sendFrame(input logic [17:0] w, input int nFalls, input bit coincide);
    busEn = 1'b1;
    waitCyc(4);
    for (int i = 0; i < nFalls; i++) begin
      busClk  = 1'b1;
      busData = (i < 18) ? w[17-i] : 1'($urandom);
      waitCyc(4);
      busClk = 1'b0;
      if (coincide && i == nFalls - 1) busEn = 1'b0;
      waitCyc(4);
    end
    busEn = 1'b0;
    waitCyc(8);
    if (nFalls == 18) begin
      expCode = w[17:14];
      for (int k = 0; k < 14; k++) expSf[k] = w[13-k];
    end
  endtask

  task automatic checkOut(input string req);
    logic [3:0] b;
    b = expBands(expCode);
    chk(scaleFactor == expSf, req, 32'(scaleFactor), 32'(expSf));
    chk({uhfOn, vhfHighOn, vhfLowOn, fmTrapOn} == b, req,
        32'({uhfOn, vhfHighOn, vhfLowOn, fmTrapOn}), 32'(b));
    chk({pumpEnable, driveEnable} == {2{expSf != 0}}, "R8",
        32'({pumpEnable, driveEnable}), 32'({2{expSf != 0}}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [5];
    codes = '{4'b1000, 4'b0100, 4'b0010, 4'b0011, 4'b1111};
    void'($urandom(32'd20240611));
    waitCyc(5);
    // R1 reset state
    chk(scaleFactor == 0 && !uhfOn && !vhfHighOn && !vhfLowOn && !fmTrapOn, "R1",
        32'(scaleFactor), 0);
    chk(!pumpEnable && !driveEnable && !lockInd, "R1",
        32'({pumpEnable, driveEnable, lockInd}), 0);
    rstN = 1'b1;
    waitCyc(3);
    // R9 fixed settings
    chk(refDivRatio == 10'd512 && pumpHighCurrent, "R9", 32'(refDivRatio), 512);

    // R2 R6 directed table
    sendFrame(mkWord(4'b1000, 14'h2A5B), 18, 0); checkOut("R2 R6 uhf");
    sendFrame(mkWord(4'b0100, 14'h0001), 18, 0); checkOut("R6 vhfHigh");
    sendFrame(mkWord(4'b0010, 14'h2000), 18, 0); checkOut("R6 vhfLow");
    sendFrame(mkWord(4'b0011, 14'h1234), 18, 0); checkOut("R6 ch6 trap");
    // R7 unlisted code
    sendFrame(mkWord(4'b0110, 14'h0F0F), 18, 0); checkOut("R7 unlisted");
    // R3 wrong counts
    sendFrame(mkWord(4'b1000, 14'h3333), 17, 0); checkOut("R3 count17");
    sendFrame(mkWord(4'b1000, 14'h3333), 19, 0); checkOut("R3 count19");
    sendFrame(mkWord(4'b1000, 14'h3333), 0, 0);  checkOut("R3 count0");
    // R5 saturation
    sendFrame(mkWord(4'b0100, 14'h1555), 50, 0); checkOut("R5 saturate");
    // R4 clocks with enable low
    busEn = 1'b0;
    for (int i = 0; i < 18; i++) begin
      busClk = 1'b1; busData = 1'b1; waitCyc(4);
      busClk = 1'b0; waitCyc(4);
    end
    checkOut("R4 ignored");
    sendFrame(mkWord(4'b0010, 14'h0ABC), 18, 0); checkOut("R4 after");
    // R11 coincident last fall
    sendFrame(mkWord(4'b1000, 14'h2001), 18, 1); checkOut("R11 coincide18");
    sendFrame(mkWord(4'b0100, 14'h1111), 17, 1); checkOut("R11 coincide17");
    sendFrame(mkWord(4'b0100, 14'h1111), 19, 1); checkOut("R11 coincide19");

    // R10 lock indicator
    loopLocked = 1'b1; waitCyc(1);
    chk(lockInd == 1'b1, "R10 locked", 32'(lockInd), 1);
    loopLocked = 1'b0; waitCyc(1);
    chk(lockInd == 1'b0, "R10 unlocked", 32'(lockInd), 0);
    // R8 zero scaling factor
    sendFrame(mkWord(4'b1000, 14'h0000), 18, 0); checkOut("R8 zero");
    loopLocked = 1'b1; waitCyc(2);
    chk(lockInd == 1'b0, "R10 disabled", 32'(lockInd), 0);
    loopLocked = 1'b0;

    // random mix
    for (int it = 0; it < 40; it++) begin
      int sel, nf;
      logic [3:0] c;
      logic [13:0] sf;
      sel = $urandom_range(0, 5);
      c = (sel < 5) ? codes[sel] : 4'($urandom);
      sf = 14'($urandom);
      case ($urandom_range(0, 4))
        0, 1: nf = 18;
        2: nf = 17;
        3: nf = 19;
        default: nf = $urandom_range(0, 40);
      endcase
      sendFrame(mkWord(c, sf), nf, 1'($urandom));
      checkOut("R2 R3 random");
    end

    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule